// File: doc/BRIEF.md
# ATM Receive Cell Header Filter

This block sits on the receive side of one ATM link, after cell delineation. It takes the cell stream one byte per clock, with a strobe marking the first byte of each 53-byte cell. For every cell it checks the four header bytes against the header check byte, can repair a header with a single flipped bit, and sorts the cell as user traffic or as idle/unassigned filler. Depending on the per-link settings it drops cells with a bad header check or filler cells, and it can undo the self-synchronising payload scrambling. Surviving cells leave on a byte port with their own valid and start strobes. A counter follows either user cells or filler cells.

The drop decision can only be made once the check byte has arrived, so the block holds five bytes in a short delay line. An output byte appears one clock after the input beat that carries the byte five valid beats later. The tail of a cell therefore leaves only as further bytes (of the next cell, or bytes outside any cell) arrive. Settings are taken from the configuration inputs on the start beat of each cell.

Top module: `atm_rx_hdr_filter`

## Requirements
- R1: An input byte taken on a valid beat is emitted on `out_byte`, in input order, one clock after the valid beat that comes five beats later. `out_soc` marks the first header byte of a kept cell, and `out_valid` is low in every other cycle. After reset `out_valid`, `out_soc` and `cell_count` are 0.
- R2: The syndrome is computed as CRC-8 (generator x^8+x^2+x+1, header byte 1 first, MSB first, zero initial value) of the four header bytes, XOR 0x55, XOR the fifth byte. A zero syndrome marks a good header.
- R3: When `cfg_no_coset` is 1, the 0x55 term is left out of the syndrome.
- R4: When `cfg_correct` is 1 and a non-zero syndrome equals that of a single flipped bit among the 40 header and check bits, that bit is inverted in the emitted header or check byte and the cell counts as good. When `cfg_correct` is 0, no byte is altered.
- R5: A cell whose header is neither good nor repaired is dropped entirely when `cfg_drop_bad_hec` is 1. When it is 0, the cell is emitted with its received header.
- R6: A good or repaired header whose 32 bits are all zero except possibly the last bit is idle/unassigned filler. Such a cell is dropped entirely when `cfg_drop_idle` is 1. Header-check classification takes precedence, so a bad header is never treated as filler.
- R7: `cell_count` advances by one, modulo 2^CNT_W, for each good or repaired cell. It counts user cells when `cfg_count_user` is 1 and filler cells when it is 0. Dropping a cell does not stop it from being counted, and bad headers are never counted.
- R8: The 48 payload bytes are descrambled MSB first with out = in XOR the received bit 43 bits earlier, when `cfg_descramble` is 1. The history covers only payload bits of all cells, kept or dropped, continues across cells, starts at zero and is updated whatever the enable.
- R9: All six settings are taken on the start beat of a cell and hold for that whole cell. The configuration inputs on the other beats have no effect.
- R10: Bytes that arrive after byte 53 of a cell and before the next start beat are never emitted, and they leave the descrambler history untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_soc | input | 1 | Input byte is the first header byte of a cell |
| in_byte | input | 8 | Received byte |
| cfg_descramble | input | 1 | Descramble payload |
| cfg_count_user | input | 1 | 1: count user cells, 0: count filler cells |
| cfg_drop_idle | input | 1 | Drop idle/unassigned cells |
| cfg_drop_bad_hec | input | 1 | Drop cells with an unrepaired header error |
| cfg_no_coset | input | 1 | Check header without the 0x55 term |
| cfg_correct | input | 1 | Repair single-bit header errors |
| out_valid | output | 1 | Output byte present this cycle |
| out_soc | output | 1 | Output byte is the first header byte of a cell |
| out_byte | output | 8 | Emitted byte |
| cell_count | output | CNT_W | Wrapping cell counter |

## Verification
Header repair and filler classification meet on the same check beat. A cell of all-zero header bits with one injected bit error must first be repaired, then recognised as unassigned, then counted or dropped. The same beat also releases the last byte of the previous cell under that cell's own decision. The sweep runs every setting combination against good, single-error, double-error, wrong-coset, idle and damaged unassigned cells. Every emitted byte, and the counter after each cell, is compared with an arithmetic model built in the bench.

// File: rtl/atmf_pkg.sv
package atmf_pkg;

  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = 4;
  localparam int HDR_BITS = HDR_LEN * 8;
  localparam int CW_BITS  = HDR_BITS + 8;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef struct packed {
    logic descr;
    logic count_user;
    logic drop_idle;
    logic drop_bad;
    logic no_coset;
    logic correct;
  } cell_cfg_t;

  typedef struct packed {
    logic       used;
    logic       first;
    logic [7:0] data;
  } slot_t;

  // CRC-8 remainder of the header word, first byte in the top bits, MSB first.
  function automatic logic [7:0] crc8_word(input logic [HDR_BITS-1:0] w);
    logic [7:0] r;
    logic       fb;
    r = '0;
    for (int i = HDR_BITS - 1; i >= 0; i--) begin
      fb = r[7] ^ w[i];
      r  = {r[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
    end
    return r;
  endfunction

  // Idle and unassigned cells share all-zero header bits apart from the last bit.
  function automatic logic is_filler(input logic [HDR_BITS-1:0] h);
    return h[HDR_BITS-1:1] == '0;
  endfunction

endpackage

// File: rtl/atmf_hec_eval.sv
module atmf_hec_eval
  import atmf_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr_in,
  input  logic [7:0]          hec_in,
  input  logic                no_coset,
  input  logic                correct_en,
  output logic [HDR_BITS-1:0] hdr_out,
  output logic [7:0]          hec_out,
  output logic                hdr_ok,
  output logic                hdr_fixed
);

  logic [7:0]         syn;
  logic [CW_BITS-1:0] hit;
  logic [CW_BITS-1:0] flip;
  logic               syn_zero;
  logic               syn_single;

  assign syn = crc8_word(hdr_in) ^ (no_coset ? 8'h00 : HEC_COSET) ^ hec_in;

  generate
    for (genvar i = 0; i < HDR_BITS; i++) begin : g_hdr_pat
      localparam logic [7:0] PAT = crc8_word(HDR_BITS'(1) << i);
      assign hit[i+8] = (syn == PAT);
    end
    for (genvar j = 0; j < 8; j++) begin : g_hec_pat
      assign hit[j] = (syn == (8'h01 << j));
    end
  endgenerate

  assign syn_zero   = (syn == 8'h00);
  assign syn_single = |hit;
  assign hdr_fixed  = !syn_zero && correct_en && syn_single;
  assign flip       = hdr_fixed ? hit : '0;
  assign {hdr_out, hec_out} = {hdr_in, hec_in} ^ flip;
  assign hdr_ok     = syn_zero || hdr_fixed;

  // R4: single-bit syndromes are distinct, so at most one position matches
  always_comb begin
    assert_single_match_R4: assert ($onehot0(hit))
      else $error("more than one single-bit syndrome matched");
  end

endmodule

// File: rtl/atmf_descrambler.sv
module atmf_descrambler #(
  parameter int TAP = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       enable,
  input  logic [7:0] din,
  output logic [7:0] dout
);

  logic [TAP-1:0] hist_q;
  logic [TAP-1:0] hist_d;
  logic [7:0]     plain;

  always_comb begin
    hist_d = hist_q;
    plain  = '0;
    for (int b = 7; b >= 0; b--) begin
      plain[b] = din[b] ^ hist_d[TAP-1];
      hist_d   = {hist_d[TAP-2:0], din[b]};
    end
  end

  assign dout = enable ? plain : din;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (step) hist_q <= hist_d;
  end

  // R8: history holds the received (scrambled) bits, newest byte at the bottom
  assert_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> hist_q[7:0] == $past(din))
    else $error("descrambler history does not hold the last payload byte");

endmodule

// File: rtl/atmf_cell_counter.sv
module atmf_cell_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (bump) count <= count + 1'b1;
  end

  // R7: the counter only ever moves forward by one
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |-> count == $past(count) + 1'b1)
    else $error("cell counter jumped");

endmodule

// File: rtl/atm_rx_hdr_filter.sv
module atm_rx_hdr_filter
  import atmf_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SCR_TAP = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic [7:0]       in_byte,
  input  logic             cfg_descramble,
  input  logic             cfg_count_user,
  input  logic             cfg_drop_idle,
  input  logic             cfg_drop_bad_hec,
  input  logic             cfg_no_coset,
  input  logic             cfg_correct,
  output logic             out_valid,
  output logic             out_soc,
  output logic [7:0]       out_byte,
  output logic [CNT_W-1:0] cell_count
);

  localparam int LINE_LEN = HDR_LEN + 1;
  localparam int LAST     = LINE_LEN - 1;
  localparam int IDX_W    = $clog2(CELL_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_OUT = IDX_W'(CELL_LEN);
  localparam logic [IDX_W-1:0] IDX_HEC = IDX_W'(HDR_LEN);

  // ---------------- cell position and settings ----------------
  cell_cfg_t        cfg_in, cfg_q;
  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             in_cell, at_hec, at_pay, take_hec, take_pay;

  assign cfg_in = '{descr:      cfg_descramble,
                    count_user: cfg_count_user,
                    drop_idle:  cfg_drop_idle,
                    drop_bad:   cfg_drop_bad_hec,
                    no_coset:   cfg_no_coset,
                    correct:    cfg_correct};

  assign cur_idx  = in_soc ? '0 : idx_q;
  assign in_cell  = cur_idx < IDX_OUT;
  assign at_hec   = cur_idx == IDX_HEC;
  assign at_pay   = in_cell && (cur_idx > IDX_HEC);
  assign take_hec = in_valid && at_hec;
  assign take_pay = in_valid && at_pay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= IDX_OUT;
      cfg_q <= '0;
    end else if (in_valid) begin
      idx_q <= in_cell ? cur_idx + 1'b1 : IDX_OUT;
      if (in_soc) cfg_q <= cfg_in;
    end
  end

  // ---------------- payload descrambling on entry ----------------
  logic [7:0] pay_plain;

  atmf_descrambler #(.TAP(SCR_TAP)) u_descr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (take_pay),
    .enable (cfg_q.descr),
    .din    (in_byte),
    .dout   (pay_plain)
  );

  // ---------------- five-byte delay line ----------------
  slot_t line_q [LINE_LEN];
  slot_t line_d [LINE_LEN];
  slot_t fresh;

  logic [HDR_BITS-1:0] hdr_win, hdr_fix;
  logic [7:0]          hec_fix;
  logic                hdr_ok, hdr_fixed, filler;

  always_comb begin
    for (int k = 0; k < HDR_LEN; k++) hdr_win[8*k +: 8] = line_q[k].data;
  end

  atmf_hec_eval u_hec (
    .hdr_in     (hdr_win),
    .hec_in     (in_byte),
    .no_coset   (cfg_q.no_coset),
    .correct_en (cfg_q.correct),
    .hdr_out    (hdr_fix),
    .hec_out    (hec_fix),
    .hdr_ok     (hdr_ok),
    .hdr_fixed  (hdr_fixed)
  );

  assign filler = is_filler(hdr_fix);
  assign fresh  = '{used: in_cell, first: in_soc, data: (at_pay ? pay_plain : in_byte)};

  // On the check beat the (possibly repaired) header is written back into the line.
  always_comb begin
    if (at_hec) begin
      for (int k = 1; k < LINE_LEN; k++)
        line_d[k] = '{used: line_q[k-1].used, first: line_q[k-1].first,
                      data: hdr_fix[8*(k-1) +: 8]};
      line_d[0] = '{used: 1'b1, first: 1'b0, data: hec_fix};
    end else begin
      for (int k = 1; k < LINE_LEN; k++) line_d[k] = line_q[k-1];
      line_d[0] = fresh;
    end
  end

  // ---------------- per-cell decision ----------------
  logic keep_new, keep_q, count_hit;

  assign keep_new  = hdr_ok ? !(filler && cfg_q.drop_idle) : !cfg_q.drop_bad;
  assign count_hit = take_hec && hdr_ok && (cfg_q.count_user ? !filler : filler);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LINE_LEN; k++) line_q[k] <= '0;
      keep_q    <= 1'b0;
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_byte  <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < LINE_LEN; k++) line_q[k] <= line_d[k];
      if (at_hec) keep_q <= keep_new;
      out_valid <= line_q[LAST].used && keep_q;
      out_soc   <= line_q[LAST].used && line_q[LAST].first && keep_q;
      out_byte  <= line_q[LAST].data;
    end else begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
    end
  end

  atmf_cell_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (count_hit),
    .count (cell_count)
  );

  // ---------------- assertion support ----------------
  logic                hdr_seen_q;
  logic [IDX_W-1:0]    ob_cnt_q;
  logic [HDR_BITS-1:0] line_hdr;

  always_comb begin
    for (int k = 0; k < HDR_LEN; k++) line_hdr[8*k +: 8] = line_q[k+1].data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_seen_q <= 1'b0;
      ob_cnt_q   <= '0;
    end else begin
      if (in_valid) hdr_seen_q <= take_hec && hdr_ok;
      if (out_valid) ob_cnt_q <= out_soc ? IDX_W'(1) : ob_cnt_q + 1'b1;
    end
  end

  // R4: a header accepted as good or repaired sits in the line with a matching check byte
  assert_fixed_consistent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_seen_q |-> (crc8_word(line_hdr) ^ (cfg_q.no_coset ? 8'h00 : HEC_COSET)) == line_q[0].data)
    else $error("accepted header does not match its check byte");

  // R1: start strobe only together with a valid byte
  assert_soc_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid)
    else $error("out_soc without out_valid");

  // R1: a cell never runs past 53 emitted bytes
  assert_cell_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_soc) |-> (ob_cnt_q < IDX_OUT))
    else $error("emitted cell longer than 53 bytes");

endmodule

// File: tb/atm_rx_hdr_filter_tb.sv
module atm_rx_hdr_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int SCR_TAP    = 43;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_soc = 1'b0;
  logic [7:0]       in_byte = '0;
  logic             cfg_descramble = 1'b0;
  logic             cfg_count_user = 1'b0;
  logic             cfg_drop_idle = 1'b0;
  logic             cfg_drop_bad_hec = 1'b0;
  logic             cfg_no_coset = 1'b0;
  logic             cfg_correct = 1'b0;
  logic             out_valid, out_soc;
  logic [7:0]       out_byte;
  logic [CNT_W-1:0] cell_count;

  atm_rx_hdr_filter #(.CNT_W(CNT_W), .SCR_TAP(SCR_TAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc), .in_byte(in_byte),
    .cfg_descramble(cfg_descramble), .cfg_count_user(cfg_count_user),
    .cfg_drop_idle(cfg_drop_idle), .cfg_drop_bad_hec(cfg_drop_bad_hec),
    .cfg_no_coset(cfg_no_coset), .cfg_correct(cfg_correct),
    .out_valid(out_valid), .out_soc(out_soc), .out_byte(out_byte), .cell_count(cell_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cnt_m  = 0;
  logic [8:0] exp_q[$];
  string      exp_req[$];
  bit         pay_bits[$];
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // polynomial long division of header * x^8 by x^8+x^2+x+1
  function automatic logic [7:0] bench_hec(input logic [31:0] h);
    logic [39:0] v;
    v = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    return v[7:0];
  endfunction

  function automatic logic [7:0] model_descr(input logic [7:0] s);
    logic [7:0] r;
    int n;
    for (int b = 7; b >= 0; b--) begin
      n = pay_bits.size();
      r[b] = s[b] ^ ((n >= SCR_TAP) ? pay_bits[n-SCR_TAP] : 1'b0);
      pay_bits.push_back(s[b]);
    end
    return r;
  endfunction

  function automatic logic [7:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[7:0];
  endfunction

  // c: [0] descramble [1] count user [2] drop idle [3] drop bad [4] no coset [5] correct
  task automatic put(input logic [7:0] b, input bit soc, input logic [5:0] c);
    @(posedge clk); #1;
    in_valid = 1'b1; in_soc = soc; in_byte = b;
    {cfg_correct, cfg_no_coset, cfg_drop_bad_hec, cfg_drop_idle, cfg_count_user, cfg_descramble} = c;
  endtask

  task automatic idle_beats(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_soc = 1'b0;
    end
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [39:0] err,
                           input bit tx_coset, input logic [5:0] c, input bit mid_gap);
    logic [39:0] cw, fixed, t;
    logic [7:0]  syn, raw [53], outb [53];
    bit          ok, iu, keep;
    string       rq, prq;
    cw    = {hdr, bench_hec(hdr) ^ (tx_coset ? 8'h55 : 8'h00)} ^ err;
    syn   = bench_hec(cw[39:8]) ^ (c[4] ? 8'h00 : 8'h55) ^ cw[7:0];
    ok    = (syn == 8'h00);
    fixed = cw;
    if (!ok && c[5]) begin
      for (int k = 0; k < 40; k++) begin
        t = cw ^ (40'd1 << k);
        if (!ok && (bench_hec(t[39:8]) ^ (c[4] ? 8'h00 : 8'h55) ^ t[7:0]) == 8'h00) begin
          fixed = t; ok = 1'b1;
        end
      end
    end
    iu   = (fixed[39:9] == '0);
    keep = ok ? !(iu && c[2]) : !c[3];
    if (ok && (c[1] ? !iu : iu)) cnt_m++;
    rq  = !ok ? "R5" : (fixed != cw) ? "R4" : iu ? "R6" : c[4] ? "R3" : "R2";
    prq = c[0] ? "R8,R9" : "R1,R9";
    for (int k = 0; k < 5; k++) begin
      raw[k]  = cw[39-8*k -: 8];
      outb[k] = ok ? fixed[39-8*k -: 8] : cw[39-8*k -: 8];
    end
    for (int k = 5; k < 53; k++) begin
      raw[k]  = next_rand();
      outb[k] = model_descr(raw[k]);
      if (!c[0]) outb[k] = raw[k];
    end
    if (keep) begin
      for (int k = 0; k < 53; k++) begin
        exp_q.push_back({(k == 0), outb[k]});
        exp_req.push_back(k < 5 ? rq : prq);
      end
    end
    // R9: settings on non-start beats are inverted and must be ignored
    put(raw[0], 1'b1, c);
    for (int k = 1; k < 53; k++) begin
      if (mid_gap && k == 17) idle_beats(2);
      put(raw[k], 1'b0, ~c);
    end
    chk(cell_count == CNT_W'(cnt_m), "R7", "cell_count after cell", cell_count, CNT_W'(cnt_m));
  endtask

  always @(negedge clk) begin : monitor
    logic [8:0] e;
    string r;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R10", "unexpected output byte", {out_soc, out_byte}, 0);
      else begin
        e = exp_q.pop_front();
        r = exp_req.pop_front();
        chk({out_soc, out_byte} == e, r, "output {soc,byte}", {out_soc, out_byte}, e);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] user_hdr;
    int p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(out_soc == 1'b0, "R1", "out_soc in reset", out_soc, 0);
    chk(cell_count == '0, "R7", "cell_count in reset", cell_count, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    for (int c = 0; c < 64; c++) begin
      user_hdr = {8'h3C ^ 8'(c), 8'h11, 8'h22 + 8'(c), 8'h40};
      p = (c * 7) % 40;
      send_cell(user_hdr, 40'd0, !c[4], 6'(c), c[1]);                           // good user
      send_cell(user_hdr, 40'd1 << p, !c[4], 6'(c), 1'b0);                      // one bit
      send_cell(user_hdr, (40'd1 << p) | (40'd1 << ((p + 13) % 40)), !c[4], 6'(c), 1'b0); // two bits
      send_cell(32'h0000_0001, 40'd0, !c[4], 6'(c), 1'b0);                      // idle
      send_cell(32'h0000_0000, 40'd1 << ((c * 3 + 5) % 40), !c[4], 6'(c), c[0]); // damaged unassigned
      send_cell(user_hdr, 40'd0, c[4], 6'(c), 1'b0);                            // wrong coset mode
      if (c % 8 == 3) begin
        // R10: bytes outside any cell
        for (int k = 0; k < 3; k++) put(8'hA5 + 8'(k), 1'b0, 6'(c));
        idle_beats(2);
      end
    end
    // R10: flush the tail with stray bytes, which themselves must not appear
    for (int k = 0; k < 6; k++) put(8'h5A, 1'b0, 6'd0);
    idle_beats(10);
    chk(exp_q.size() == 0, "R10", "expected bytes left unemitted", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R1", "out_valid idle at end", out_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule